// File: doc/BRIEF.md
# I2S Audio Receive Channel

This block takes a serial audio stream made of a word-select line and a data line, clocked by a bit clock, and turns it into 32-bit words in an internal receive queue. It runs on the chip's system clock. The bit clock arrives as `bit_tick`, a one-cycle strobe on each rising bit-clock edge, already synchronized. Each strobe samples the serial lines once.

Configuration inputs set the following:
- the sample width: 8, 16 or 32 bits;
- mono or stereo format;
- a stop control and a channel clear;
- whether the block generates word select itself or follows an external one;
- the generated word-select half period;
- three fill thresholds behind the status flags.

Samples are captured MSB first and packed from the low end of each queue word. A parallel read port drains the queue. An interrupt flag and two DMA request levels report the fill state.

Top module: `i2s_rx_chan`

## Requirements
- R1: After `rst`, the queue is empty (`fifo_level` = 0), `irq`, `dma_req1` and `dma_req2` are 0, and `ws_out` is 0.
- R2: `cfg_width` decodes as follows: 2'b00 gives 8 bits, 2'b01 gives 16 bits, 2'b11 gives 32 bits. The reserved code 2'b10 behaves exactly like 16 bits.
- R3: A change of word select, seen at a tick, starts a new sample. The MSB is taken at the following tick, and the next bits follow MSB first. Only the configured number of bits is kept, and later bits in the same half are ignored. The LSB of a full-width sample may fall on the tick that carries the next word-select change.
- R4: Accepted samples fill a queue word from bit 0 upward. An 8-bit sample k occupies bits [8k+7:8k]. A 16-bit sample k occupies bits [16k+15:16k]. A 32-bit sample fills the whole word. In stereo, samples from both word-select levels are taken in arrival order. A word enters the queue only when it is full.
- R5: With `cfg_mono` = 1, only samples captured while word select is low are kept. Samples captured with word select high are discarded.
- R6: With `cfg_ws_slave` = 0, `ws_out` is generated internally and used for capture. A tick counter runs from 0. On a tick where the counter equals `cfg_half`, `ws_out` toggles and the counter restarts. This gives a full period of 2*(`cfg_half`+1) ticks.
- R7: With `cfg_ws_slave` = 1, capture follows `ws_in`, `cfg_half` has no effect, and `ws_out` stays 0.
- R8: The queue holds 8 words. `rd_data` shows the oldest word without a request. `rd_en` with a non-empty queue removes that word.
- R9: A completed word that arrives while the queue holds 8 words is discarded, and the stored words are kept.
- R10: While `cfg_stop` = 1, no word enters the queue and `rd_en` removes nothing.
- R11: `cfg_chan_rst` = 1 empties the queue, clears any partly packed word and partial sample, and restarts the word-select generator at 0 with its counter at 0.
- R12: Each of `irq`, `dma_req1` and `dma_req2` is 1 exactly when its threshold (`irq_level`, `dma1_level`, `dma2_level`) is nonzero and `fifo_level` is at least that threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe per rising bit-clock edge |
| ws_in | input | 1 | External word select (slave role) |
| sd_in | input | 1 | Serial data |
| ws_out | output | 1 | Generated word select (master role), 0 in slave role |
| cfg_width | input | 2 | Sample width code |
| cfg_mono | input | 1 | 1 = mono, 0 = stereo |
| cfg_stop | input | 1 | Blocks queue writes and reads |
| cfg_chan_rst | input | 1 | Clears the channel state and the queue |
| cfg_ws_slave | input | 1 | 1 = follow `ws_in`, 0 = generate word select |
| cfg_half | input | 9 | Generated word-select half period minus one |
| irq_level | input | 4 | Interrupt fill threshold, 0 = off |
| dma1_level | input | 4 | DMA request 1 fill threshold, 0 = off |
| dma2_level | input | 4 | DMA request 2 fill threshold, 0 = off |
| rd_en | input | 1 | Removes the oldest word |
| rd_data | output | 32 | Oldest word in the queue |
| fifo_level | output | 4 | Number of stored words |
| irq | output | 1 | Interrupt flag |
| dma_req1 | output | 1 | DMA request level 1 |
| dma_req2 | output | 1 | DMA request level 2 |

## Verification
The capture-and-pack path is driven with 8-bit, 16-bit and 32-bit stereo streams and with the reserved width code. Their different word layouts separate width decoding from lane placement. Every half period is padded with ones after the sample's LSB, so a design that keeps extra bits is caught. The 32-bit case uses a half period equal to the sample width, so its LSB lands on the next word-select change. Mono streams, one of which never completes a word, separate level-based sample filtering from plain packing. A run with internal word select compares `ws_out` against an independently computed toggle pattern while data is captured against it.

// File: rtl/i2srx_pkg.sv
package i2srx_pkg;

    localparam int SMP_W  = 32;
    localparam int HALF_W = 9;
    localparam int BCNT_W = $clog2(SMP_W + 1);

    typedef enum logic [1:0] {
        WID_8   = 2'b00,
        WID_16  = 2'b01,
        WID_RSV = 2'b10,
        WID_32  = 2'b11
    } wid_e;

    typedef struct packed {
        logic             vld;
        logic             chan;
        logic [SMP_W-1:0] data;
    } sample_t;

    function automatic logic [BCNT_W-1:0] width_bits(input logic [1:0] w);
        case (wid_e'(w))
            WID_8:   return BCNT_W'(8);
            WID_32:  return BCNT_W'(32);
            default: return BCNT_W'(16);
        endcase
    endfunction

    function automatic logic [2:0] slots_per_word(input logic [1:0] w);
        case (wid_e'(w))
            WID_8:   return 3'd4;
            WID_32:  return 3'd1;
            default: return 3'd2;
        endcase
    endfunction

endpackage

// File: rtl/i2srx_wsgen.sv
module i2srx_wsgen
    import i2srx_pkg::*;
#(
    parameter int HW = HALF_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          tick,
    input  logic          enable,
    input  logic [HW-1:0] half,
    output logic          ws
);

    logic [HW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr || !enable) begin
            cnt <= '0;
            ws  <= 1'b0;
        end else if (tick) begin
            if (cnt >= half) begin
                cnt <= '0;
                ws  <= ~ws;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R6
    ws_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clr && enable) |=> $stable(ws));

endmodule

// File: rtl/i2srx_deser.sv
module i2srx_deser
    import i2srx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       tick,
    input  logic       ws,
    input  logic       sd,
    input  logic [1:0] wid,
    output sample_t    smp
);

    logic              ws_prev;
    logic              active;
    logic              chan;
    logic [BCNT_W-1:0] cnt;
    logic [SMP_W-1:0]  sh;
    logic [SMP_W-1:0]  sh_next;
    logic [BCNT_W-1:0] cnt_next;
    logic [BCNT_W-1:0] nbits;
    logic              ws_edge;

    always_comb begin
        sh_next  = {sh[SMP_W-2:0], sd};
        cnt_next = cnt + 1'b1;
        nbits    = width_bits(wid);
        ws_edge  = (ws != ws_prev);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ws_prev <= 1'b0;
            active  <= 1'b0;
            chan    <= 1'b0;
            cnt     <= '0;
            sh      <= '0;
            smp     <= '0;
        end else begin
            smp.vld <= 1'b0;
            if (tick) begin
                ws_prev <= ws;
                if (active) begin
                    if (cnt_next == nbits) begin
                        smp.vld  <= 1'b1;
                        smp.data <= sh_next;
                        smp.chan <= chan;
                        active   <= 1'b0;
                    end else begin
                        sh  <= sh_next;
                        cnt <= cnt_next;
                    end
                end
                if (ws_edge) begin
                    active <= 1'b1;
                    cnt    <= '0;
                    sh     <= '0;
                    chan   <= ws;
                end
            end
        end
    end

    // R3
    smp_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        smp.vld |-> $past(tick));

endmodule

// File: rtl/i2srx_packer.sv
module i2srx_packer
    import i2srx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  sample_t          smp,
    input  logic [1:0]       wid,
    input  logic             mono,
    input  logic             stop,
    output logic             word_vld,
    output logic [SMP_W-1:0] word
);

    logic [SMP_W-1:0] acc;
    logic [SMP_W-1:0] acc_next;
    logic [2:0]       slot;
    logic             accept;
    logic             last;

    always_comb begin
        accept = smp.vld && !stop && !(mono && smp.chan);
        last   = ((slot + 3'd1) >= slots_per_word(wid));
        case (wid_e'(wid))
            WID_8:   acc_next = acc | (SMP_W'(smp.data[7:0])  << (slot * 8));
            WID_32:  acc_next = smp.data;
            default: acc_next = acc | (SMP_W'(smp.data[15:0]) << (slot * 16));
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc      <= '0;
            slot     <= '0;
            word     <= '0;
            word_vld <= 1'b0;
        end else begin
            word_vld <= 1'b0;
            if (accept) begin
                if (last) begin
                    word     <= acc_next;
                    word_vld <= 1'b1;
                    acc      <= '0;
                    slot     <= '0;
                end else begin
                    acc  <= acc_next;
                    slot <= slot + 3'd1;
                end
            end
        end
    end

    // R4
    push_after_smp_chk: assert property (@(posedge clk) disable iff (rst)
        word_vld |-> $past(smp.vld));

endmodule

// File: rtl/i2srx_fifo.sv
module i2srx_fifo #(
    parameter  int DEPTH = 8,
    parameter  int W     = 32,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [LW-1:0] level,
    output logic          full
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          do_push;
    logic          do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full    = (level == LW'(DEPTH));
        do_push = push && !full;
        do_pop  = pop && (level != '0);
        rdata   = mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop)      level <= level + 1'b1;
            else if (do_pop && !do_push) level <= level - 1'b1;
        end
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        level <= LW'(DEPTH));

    // R9
    full_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (full && !pop && !clr) |=> full);

endmodule

// File: rtl/i2s_rx_chan.sv
module i2s_rx_chan
    import i2srx_pkg::*;
#(
    parameter  int FIFO_DEPTH = 8,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              ws_in,
    input  logic              sd_in,
    output logic              ws_out,
    input  logic [1:0]        cfg_width,
    input  logic              cfg_mono,
    input  logic              cfg_stop,
    input  logic              cfg_chan_rst,
    input  logic              cfg_ws_slave,
    input  logic [HALF_W-1:0] cfg_half,
    input  logic [LVL_W-1:0]  irq_level,
    input  logic [LVL_W-1:0]  dma1_level,
    input  logic [LVL_W-1:0]  dma2_level,
    input  logic              rd_en,
    output logic [SMP_W-1:0]  rd_data,
    output logic [LVL_W-1:0]  fifo_level,
    output logic              irq,
    output logic              dma_req1,
    output logic              dma_req2
);

    logic             ws_gen;
    logic             ws_use;
    sample_t          smp;
    logic             word_vld;
    logic [SMP_W-1:0] word;
    logic             q_full;

    function automatic logic at_or_above(input logic [LVL_W-1:0] lvl,
                                         input logic [LVL_W-1:0] thr);
        return (thr != '0) && (lvl >= thr);
    endfunction

    i2srx_wsgen #(.HW(HALF_W)) u_wsgen (
        .clk    (clk),
        .rst    (rst),
        .clr    (cfg_chan_rst),
        .tick   (bit_tick),
        .enable (!cfg_ws_slave),
        .half   (cfg_half),
        .ws     (ws_gen)
    );

    assign ws_use = cfg_ws_slave ? ws_in : ws_gen;
    assign ws_out = ws_gen;

    i2srx_deser u_deser (
        .clk  (clk),
        .rst  (rst),
        .clr  (cfg_chan_rst),
        .tick (bit_tick),
        .ws   (ws_use),
        .sd   (sd_in),
        .wid  (cfg_width),
        .smp  (smp)
    );

    i2srx_packer u_pack (
        .clk      (clk),
        .rst      (rst),
        .clr      (cfg_chan_rst),
        .smp      (smp),
        .wid      (cfg_width),
        .mono     (cfg_mono),
        .stop     (cfg_stop),
        .word_vld (word_vld),
        .word     (word)
    );

    i2srx_fifo #(.DEPTH(FIFO_DEPTH), .W(SMP_W)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .clr   (cfg_chan_rst),
        .push  (word_vld && !cfg_stop),
        .wdata (word),
        .pop   (rd_en && !cfg_stop),
        .rdata (rd_data),
        .level (fifo_level),
        .full  (q_full)
    );

    always_comb begin
        irq      = at_or_above(fifo_level, irq_level);
        dma_req1 = at_or_above(fifo_level, dma1_level);
        dma_req2 = at_or_above(fifo_level, dma2_level);
    end

    // R10
    stop_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_stop && !cfg_chan_rst) |=> $stable(fifo_level));

    // R7
    slave_ws_low_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_ws_slave && $past(cfg_ws_slave)) |-> !ws_out);

endmodule

// File: tb/tb_i2s_rx_chan.sv
module tb_i2s_rx_chan;

    localparam int CLK_P    = 10;
    localparam int TICK_GAP = 4;
    localparam int MAXT     = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_tick = 1'b0;
    logic        ws_in = 1'b0;
    logic        sd_in = 1'b0;
    logic        ws_out;
    logic [1:0]  cfg_width = 2'b01;
    logic        cfg_mono = 1'b0;
    logic        cfg_stop = 1'b0;
    logic        cfg_chan_rst = 1'b0;
    logic        cfg_ws_slave = 1'b1;
    logic [8:0]  cfg_half = 9'd31;
    logic [3:0]  irq_level = 4'd0;
    logic [3:0]  dma1_level = 4'd0;
    logic [3:0]  dma2_level = 4'd0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic [3:0]  fifo_level;
    logic        irq, dma_req1, dma_req2;

    int checks = 0;
    int errors = 0;
    int ws_miss;
    logic        ws_arr [MAXT];
    logic        sd_arr [MAXT];
    logic [31:0] sq [12];
    int          slen;

    typedef struct packed {
        logic [1:0]       wid;
        logic             mono;
        logic [7:0]       hl;
        logic [2:0]       nexp;
        logic [3:0][31:0] s;
        logic [3:0][31:0] e;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'b01, 1'b0, 8'd20, 3'd2,
          {32'h9EF0, 32'h5678, 32'hABCD, 32'h1234},
          {32'h0, 32'h0, 32'h9EF05678, 32'hABCD1234}},
        '{2'b00, 1'b0, 8'd12, 3'd1,
          {32'h44, 32'h33, 32'h22, 32'h11},
          {32'h0, 32'h0, 32'h0, 32'h44332211}},
        '{2'b11, 1'b0, 8'd32, 3'd4,
          {32'hCAFEF00D, 32'h89ABCDEF, 32'h01234567, 32'hDEADBEEF},
          {32'hCAFEF00D, 32'h89ABCDEF, 32'h01234567, 32'hDEADBEEF}},
        '{2'b01, 1'b1, 8'd20, 3'd1,
          {32'hDDDD, 32'hCCCC, 32'hBBBB, 32'hAAAA},
          {32'h0, 32'h0, 32'h0, 32'hCCCCAAAA}},
        '{2'b10, 1'b0, 8'd20, 3'd2,
          {32'h9EF0, 32'h5678, 32'hABCD, 32'h1234},
          {32'h0, 32'h0, 32'h9EF05678, 32'hABCD1234}},
        '{2'b00, 1'b1, 8'd16, 3'd0,
          {32'h3C, 32'hC3, 32'hA5, 32'h5A},
          {32'h0, 32'h0, 32'h0, 32'h0}}
    };

    i2s_rx_chan dut (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .ws_in(ws_in), .sd_in(sd_in),
        .ws_out(ws_out), .cfg_width(cfg_width), .cfg_mono(cfg_mono),
        .cfg_stop(cfg_stop), .cfg_chan_rst(cfg_chan_rst),
        .cfg_ws_slave(cfg_ws_slave), .cfg_half(cfg_half),
        .irq_level(irq_level), .dma1_level(dma1_level), .dma2_level(dma2_level),
        .rd_en(rd_en), .rd_data(rd_data), .fifo_level(fifo_level),
        .irq(irq), .dma_req1(dma_req1), .dma_req2(dma_req2)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic int nb(input logic [1:0] w);
        if (w == 2'b00) return 8;
        if (w == 2'b11) return 32;
        return 16;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Serial stream: a preamble at level pw, then alternating halves of hl ticks.
    // Sample k occupies half k: MSB on the tick after the change, then ones fill the half.
    task automatic build(input logic pw, input int plen, input int hl,
                         input int nbits, input int nsmp);
        for (int t = 0; t < MAXT; t++) begin
            ws_arr[t] = 1'b0;
            sd_arr[t] = 1'b0;
        end
        for (int t = 0; t < plen; t++) ws_arr[t] = pw;
        for (int k = 0; k <= nsmp; k++) begin
            for (int i = 0; i < hl; i++) ws_arr[plen + k*hl + i] = pw ^ 1'b1 ^ k[0];
            if (k < nsmp) begin
                for (int j = 0; j < nbits; j++)
                    sd_arr[plen + k*hl + 1 + j] = sq[k][nbits-1-j];
                for (int j = nbits; j < hl - 1; j++)
                    sd_arr[plen + k*hl + 1 + j] = 1'b1;
            end
        end
        slen = plen + (nsmp + 1) * hl;
    endtask

    task automatic play(input logic watch_ws);
        ws_miss = 0;
        for (int t = 0; t < slen; t++) begin
            @(negedge clk);
            if (watch_ws && (ws_out !== ws_arr[t])) ws_miss++;
            ws_in = ws_arr[t];
            sd_in = sd_arr[t];
            bit_tick = 1'b1;
            @(negedge clk);
            bit_tick = 1'b0;
            repeat (TICK_GAP - 2) @(negedge clk);
        end
        repeat (10) @(negedge clk);
    endtask

    task automatic chan_clear();
        @(negedge clk) cfg_chan_rst = 1'b1;
        repeat (2) @(negedge clk);
        cfg_chan_rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic pop1();
        @(negedge clk) rd_en = 1'b1;
        @(negedge clk) rd_en = 1'b0;
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 level", 32'(fifo_level), 32'd0);
        check("R1 flags", {29'd0, irq, dma_req1, dma_req2}, 32'd0);
        check("R1 ws_out", 32'(ws_out), 32'd0);

        // Table of stimulus and expected words (R2 R3 R4 R5 R7 R8)
        for (int v = 0; v < 6; v++) begin
            chan_clear();
            cfg_width = VECS[v].wid;
            cfg_mono  = VECS[v].mono;
            cfg_ws_slave = 1'b1;
            cfg_half  = 9'd31;
            for (int k = 0; k < 4; k++) sq[k] = VECS[v].s[k];
            build(1'b1, 2, int'(VECS[v].hl), nb(VECS[v].wid), 4);
            play(1'b0);
            check($sformatf("R4 R5 vec%0d level", v), 32'(fifo_level), 32'(VECS[v].nexp));
            for (int k = 0; k < int'(VECS[v].nexp); k++) begin
                check($sformatf("R3 R8 vec%0d word%0d", v, k), rd_data, VECS[v].e[k]);
                pop1();
            end
            check($sformatf("R7 vec%0d ws_out", v), 32'(ws_out), 32'd0);
        end

        // R6 generated word select period with half = 3
        chan_clear();
        cfg_ws_slave = 1'b0;
        cfg_half = 9'd3;
        ws_miss = 0;
        for (int t = 0; t < 20; t++) begin
            @(negedge clk);
            if (ws_out !== 1'((t / 4) % 2)) ws_miss++;
            bit_tick = 1'b1;
            @(negedge clk) bit_tick = 1'b0;
        end
        check("R6 ws toggle pattern", 32'(ws_miss), 32'd0);

        // R6 capture against generated word select, 8-bit stereo, half = 15
        cfg_ws_slave = 1'b0;
        cfg_half  = 9'd15;
        cfg_width = 2'b00;
        cfg_mono  = 1'b0;
        chan_clear();
        sq[0] = 32'h10; sq[1] = 32'h20; sq[2] = 32'h30; sq[3] = 32'h40;
        build(1'b0, 16, 16, 8, 4);
        play(1'b1);
        check("R6 ws_out follows period", 32'(ws_miss), 32'd0);
        check("R6 master level", 32'(fifo_level), 32'd1);
        check("R6 master word", rd_data, 32'h40302010);

        // R9 overflow and R12 thresholds: 10 words into 8 entries
        cfg_ws_slave = 1'b1;
        cfg_width = 2'b11;
        irq_level = 4'd3; dma1_level = 4'd6; dma2_level = 4'd9;
        chan_clear();
        for (int k = 0; k < 10; k++) sq[k] = 32'h100 + 32'(k);
        build(1'b1, 2, 32, 32, 10);
        play(1'b0);
        check("R9 level full", 32'(fifo_level), 32'd8);
        check("R12 flags at 8", {29'd0, irq, dma_req1, dma_req2}, 32'b110);
        for (int k = 0; k < 3; k++) begin
            check($sformatf("R9 kept word%0d", k), rd_data, 32'h100 + 32'(k));
            pop1();
        end
        check("R12 flags at 5", {29'd0, irq, dma_req1, dma_req2}, 32'b100);
        for (int k = 3; k < 6; k++) pop1();
        check("R12 flags at 2", {29'd0, irq, dma_req1, dma_req2}, 32'b000);
        check("R9 oldest left", rd_data, 32'h106);
        irq_level = 4'd0; dma1_level = 4'd0; dma2_level = 4'd0;

        // R10 stop blocks reads and writes
        chan_clear();
        sq[0] = 32'hA0A0A0A0; sq[1] = 32'hB1B1B1B1;
        build(1'b1, 2, 32, 32, 2);
        play(1'b0);
        check("R10 prefill", 32'(fifo_level), 32'd2);
        @(negedge clk) cfg_stop = 1'b1;
        pop1();
        check("R10 read ignored", 32'(fifo_level), 32'd2);
        check("R10 head kept", rd_data, 32'hA0A0A0A0);
        sq[0] = 32'h11111111; sq[1] = 32'h22222222;
        build(1'b1, 2, 32, 32, 2);
        play(1'b0);
        check("R10 write ignored", 32'(fifo_level), 32'd2);
        @(negedge clk) cfg_stop = 1'b0;
        pop1();
        check("R10 read after stop", rd_data, 32'hB1B1B1B1);

        // R11 channel clear empties the queue
        chan_clear();
        check("R11 level cleared", 32'(fifo_level), 32'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule